// File: doc/BRIEF.md
# IN Endpoint Send Queue

This block handles transmission for a single IN endpoint of a USB device controller. Software places packet data in a word-organised transmit memory. The memory is divided into fixed slots of 64 words. Software then writes a send register with a slot number and a byte count, and that write also sets a ready flag. When the internal holding register is empty, the block moves the request into it on its own and clears the ready flag. Software can then queue the next packet while the first one is still waiting for the host.

When the token decoder reports an IN token, the block reads the queued packet one word at a time from the slot. It emits the bytes in big-endian order on a valid/last byte stream. The packet stays in the holding register until the host acknowledges it. A handshake timeout leaves the packet in place so that the next IN token resends it. An IN token that finds nothing queued produces a NAK and sets a sticky flag. This tells software that the host was polling while nothing was queued. A transmitter-idle flag and a one-cycle interrupt report when the queue has drained. A bus reset empties both registers. Several endpoints are built by instantiating the block once per endpoint.

Top module: `in_ep_send_queue`

## Requirements
- R1: A packet in slot S reads its byte i from the memory word at address S*64 + i/4, and `mem_rd_o` is high for one cycle per word read. Read data is taken from `mem_data_i` one cycle after the read.
- R2: Bytes go out big-endian. Byte lanes 0..3 of a word are bits 31:24, 23:16, 15:8 and 7:0.
- R3: A pulse on `send_wr_i` loads the slot and length and sets `send_ready_o`. If the holding register is empty, the request moves into it on the next clock and `send_ready_o` falls. If the holding register is full, `send_ready_o` stays high until the held packet is acknowledged.
- R4: If a software write lands in the same cycle as the handoff, the holding register takes the earlier request, the new request stays pending with `send_ready_o` high, and both packets are sent in order.
- R5: An IN token with a packet held produces exactly `len` bytes on `tx_valid_o`/`tx_data_o`, with `tx_last_o` high on the final byte only. IN tokens that arrive while a packet is being sent are ignored.
- R6: A held packet with length 0 answers an IN token with a one-cycle `tx_zlp_o` pulse and no data bytes.
- R7: An IN token with nothing held gives a one-cycle `nak_o` in the next cycle and sets `nak_sent_o`. `nak_clr_i` clears the flag. A set and a clear in the same cycle leave the flag set.
- R8: An `ack_i` after a packet frees the holding register. If no request is pending, `xmit_idle_o` rises and `irq_o` pulses for exactly one cycle. An `ack_i` while no packet is awaiting a handshake has no effect.
- R9: A `timeout_i` after a packet keeps it held and `xmit_idle_o` low, and the next IN token sends the same bytes again.
- R10: A `usb_reset_i` pulse clears the ready flag and the holding register, aborts a stream in progress, clears `nak_sent_o` and sets `xmit_idle_o`, without an interrupt.
- R11: After `rst_ni` is released, `xmit_idle_o` is 1 and `send_ready_o`, `nak_sent_o`, `tx_valid_o` and `irq_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| usb_reset_i | input | 1 | Bus reset pulse |
| send_wr_i | input | 1 | Software write to the send register |
| send_slot_i | input | SLOT_W | Slot number of the packet |
| send_len_i | input | WORD_LOG2+3 | Packet length in bytes |
| send_ready_o | output | 1 | Send register ready flag |
| in_token_i | input | 1 | IN token addressed to this endpoint |
| ack_i | input | 1 | Host ACK after a packet |
| timeout_i | input | 1 | No handshake after a packet |
| mem_rd_o | output | 1 | Transmit memory read strobe |
| mem_addr_o | output | SLOT_W+WORD_LOG2 | Transmit memory word address |
| mem_data_i | input | 32 | Read data, one cycle after the strobe |
| tx_valid_o | output | 1 | Byte valid |
| tx_data_o | output | 8 | Byte out |
| tx_last_o | output | 1 | Final byte of the packet |
| tx_zlp_o | output | 1 | Zero-length packet to send |
| nak_o | output | 1 | NAK to send |
| nak_clr_i | input | 1 | Clears the NAK-sent flag |
| nak_sent_o | output | 1 | Sticky flag: host was refused |
| xmit_idle_o | output | 1 | Transmitter idle |
| irq_o | output | 1 | One-cycle idle interrupt |

## Verification
Two events can fall in the same cycle: the automatic handoff of a pending request into the holding register, and a new software write to the send register. The bench provokes this by holding one packet with a second one pending. It acknowledges the held packet and drives a third write in the very next cycle, which is the cycle in which the handoff happens. It then judges the outcome at the ports: `send_ready_o` must still be high, the next IN token must carry the second packet's bytes, and the third packet must follow after the next acknowledgement.

// File: rtl/in_ep_pkg.sv
package in_ep_pkg;
  typedef enum logic [2:0] {
    TX_IDLE  = 3'd0,
    TX_FETCH = 3'd1,
    TX_LOAD  = 3'd2,
    TX_SEND  = 3'd3,
    TX_WAIT  = 3'd4
  } tx_state_e;
endpackage

// File: rtl/ep_hold_regs.sv
module ep_hold_regs #(
  parameter int SLOT_W    = 4,
  parameter int WORD_LOG2 = 6
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          usb_rst_i,
  input  logic                          send_wr_i,
  input  logic [SLOT_W-1:0]             send_slot_i,
  input  logic [WORD_LOG2+2:0]          send_len_i,
  input  logic                          free_i,
  output logic                          send_rdy_o,
  output logic                          load_o,
  output logic                          hold_vld_o,
  output logic [SLOT_W-1:0]             hold_slot_o,
  output logic [WORD_LOG2+2:0]          hold_len_o
);
  localparam int LEN_W = WORD_LOG2 + 3;

  logic              rdy_q, hvld_q;
  logic [SLOT_W-1:0] sslot_q, hslot_q;
  logic [LEN_W-1:0]  slen_q, hlen_q;

  assign load_o      = rdy_q && !hvld_q && !usb_rst_i;
  assign send_rdy_o  = rdy_q;
  assign hold_vld_o  = hvld_q;
  assign hold_slot_o = hslot_q;
  assign hold_len_o  = hlen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_q   <= 1'b0;
      hvld_q  <= 1'b0;
      sslot_q <= '0;
      slen_q  <= '0;
      hslot_q <= '0;
      hlen_q  <= '0;
    end else if (usb_rst_i) begin
      rdy_q  <= 1'b0;
      hvld_q <= 1'b0;
    end else begin
      // handoff uses the old send contents; a same-cycle write re-arms
      if (load_o) begin
        hslot_q <= sslot_q;
        hlen_q  <= slen_q;
        hvld_q  <= 1'b1;
      end else if (free_i) begin
        hvld_q <= 1'b0;
      end
      if (send_wr_i) begin
        sslot_q <= send_slot_i;
        slen_q  <= send_len_i;
        rdy_q   <= 1'b1;
      end else if (load_o) begin
        rdy_q <= 1'b0;
      end
    end
  end

  assert_load_fills_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> hold_vld_o);
  assert_free_not_load_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_o && free_i));
  assert_usb_rst_empty_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    usb_rst_i |=> (!hold_vld_o && !send_rdy_o));
endmodule

// File: rtl/ep_tx_engine.sv
module ep_tx_engine
  import in_ep_pkg::*;
#(
  parameter int SLOT_W    = 4,
  parameter int WORD_LOG2 = 6
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          usb_rst_i,
  input  logic                          in_token_i,
  input  logic                          ack_i,
  input  logic                          timeout_i,
  input  logic                          hold_vld_i,
  input  logic [SLOT_W-1:0]             hold_slot_i,
  input  logic [WORD_LOG2+2:0]          hold_len_i,
  output logic                          mem_rd_o,
  output logic [SLOT_W+WORD_LOG2-1:0]   mem_addr_o,
  input  logic [31:0]                   mem_data_i,
  output logic                          tx_valid_o,
  output logic [7:0]                    tx_data_o,
  output logic                          tx_last_o,
  output logic                          tx_zlp_o,
  output logic                          nak_o,
  output logic                          nak_evt_o,
  output logic                          done_o
);
  localparam int BI_W  = WORD_LOG2 + 2;
  localparam int LEN_W = BI_W + 1;

  tx_state_e        state_q;
  logic [LEN_W-1:0] cnt_q;
  logic [31:0]      word_q;
  logic             zlp_q, nak_q;

  always_comb begin
    tx_valid_o = (state_q == TX_SEND);
    unique case (cnt_q[1:0])
      2'd0:    tx_data_o = word_q[31:24];
      2'd1:    tx_data_o = word_q[23:16];
      2'd2:    tx_data_o = word_q[15:8];
      default: tx_data_o = word_q[7:0];
    endcase
    tx_last_o  = tx_valid_o && ((cnt_q + 1'b1) == hold_len_i);
    mem_rd_o   = (state_q == TX_FETCH);
    mem_addr_o = {hold_slot_i, cnt_q[BI_W-1:2]};
    done_o     = (state_q == TX_WAIT) && ack_i && !usb_rst_i;
    nak_evt_o  = (state_q == TX_IDLE) && in_token_i && !hold_vld_i && !usb_rst_i;
  end

  assign tx_zlp_o = zlp_q;
  assign nak_o    = nak_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TX_IDLE;
      cnt_q   <= '0;
      word_q  <= '0;
      zlp_q   <= 1'b0;
      nak_q   <= 1'b0;
    end else begin
      zlp_q <= 1'b0;
      nak_q <= nak_evt_o;
      if (usb_rst_i) begin
        state_q <= TX_IDLE;
      end else begin
        unique case (state_q)
          TX_IDLE: if (in_token_i && hold_vld_i) begin
            cnt_q <= '0;
            if (hold_len_i == '0) begin
              zlp_q   <= 1'b1;
              state_q <= TX_WAIT;
            end else begin
              state_q <= TX_FETCH;
            end
          end
          TX_FETCH: state_q <= TX_LOAD;
          TX_LOAD: begin
            word_q  <= mem_data_i;
            state_q <= TX_SEND;
          end
          TX_SEND: begin
            cnt_q <= cnt_q + 1'b1;
            if (tx_last_o)                 state_q <= TX_WAIT;
            else if (cnt_q[1:0] == 2'b11)  state_q <= TX_FETCH;
          end
          TX_WAIT: if (ack_i || timeout_i) state_q <= TX_IDLE;
          default: state_q <= TX_IDLE;
        endcase
      end
    end
  end

  assert_stream_needs_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> hold_vld_i);
  assert_single_read_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |=> !mem_rd_o);
  assert_zlp_no_data_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_zlp_o |-> !tx_valid_o);
  assert_nak_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nak_evt_o |=> nak_o);
endmodule

// File: rtl/ep_status.sv
module ep_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic usb_rst_i,
  input  logic load_i,
  input  logic done_i,
  input  logic send_rdy_i,
  input  logic nak_evt_i,
  input  logic nak_clr_i,
  output logic xmit_idle_o,
  output logic nak_sent_o,
  output logic irq_o
);
  logic idle_q, nak_q, irq_q;

  assign xmit_idle_o = idle_q;
  assign nak_sent_o  = nak_q;
  assign irq_o       = irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idle_q <= 1'b1;
      nak_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else if (usb_rst_i) begin
      idle_q <= 1'b1;
      nak_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= done_i && !send_rdy_i;
      if (load_i)                     idle_q <= 1'b0;
      else if (done_i && !send_rdy_i) idle_q <= 1'b1;
      if (nak_evt_i)      nak_q <= 1'b1;
      else if (nak_clr_i) nak_q <= 1'b0;
    end
  end

  assert_irq_one_cycle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  assert_nak_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nak_evt_i && !usb_rst_i) |=> nak_sent_o);
  assert_usb_rst_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    usb_rst_i |=> (xmit_idle_o && !irq_o && !nak_sent_o));
endmodule

// File: rtl/in_ep_send_queue.sv
module in_ep_send_queue #(
  parameter int SLOT_W    = 4,
  parameter int WORD_LOG2 = 6,
  localparam int LEN_W    = WORD_LOG2 + 3,
  localparam int ADDR_W   = SLOT_W + WORD_LOG2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              usb_reset_i,
  input  logic              send_wr_i,
  input  logic [SLOT_W-1:0] send_slot_i,
  input  logic [LEN_W-1:0]  send_len_i,
  output logic              send_ready_o,
  input  logic              in_token_i,
  input  logic              ack_i,
  input  logic              timeout_i,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [31:0]       mem_data_i,
  output logic              tx_valid_o,
  output logic [7:0]        tx_data_o,
  output logic              tx_last_o,
  output logic              tx_zlp_o,
  output logic              nak_o,
  input  logic              nak_clr_i,
  output logic              nak_sent_o,
  output logic              xmit_idle_o,
  output logic              irq_o
);
  logic              load, hold_vld, done, nak_evt;
  logic [SLOT_W-1:0] hold_slot;
  logic [LEN_W-1:0]  hold_len;

  ep_hold_regs #(.SLOT_W(SLOT_W), .WORD_LOG2(WORD_LOG2)) u_hold (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .usb_rst_i   (usb_reset_i),
    .send_wr_i   (send_wr_i),
    .send_slot_i (send_slot_i),
    .send_len_i  (send_len_i),
    .free_i      (done),
    .send_rdy_o  (send_ready_o),
    .load_o      (load),
    .hold_vld_o  (hold_vld),
    .hold_slot_o (hold_slot),
    .hold_len_o  (hold_len)
  );

  ep_tx_engine #(.SLOT_W(SLOT_W), .WORD_LOG2(WORD_LOG2)) u_eng (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .usb_rst_i   (usb_reset_i),
    .in_token_i  (in_token_i),
    .ack_i       (ack_i),
    .timeout_i   (timeout_i),
    .hold_vld_i  (hold_vld),
    .hold_slot_i (hold_slot),
    .hold_len_i  (hold_len),
    .mem_rd_o    (mem_rd_o),
    .mem_addr_o  (mem_addr_o),
    .mem_data_i  (mem_data_i),
    .tx_valid_o  (tx_valid_o),
    .tx_data_o   (tx_data_o),
    .tx_last_o   (tx_last_o),
    .tx_zlp_o    (tx_zlp_o),
    .nak_o       (nak_o),
    .nak_evt_o   (nak_evt),
    .done_o      (done)
  );

  ep_status u_stat (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .usb_rst_i   (usb_reset_i),
    .load_i      (load),
    .done_i      (done),
    .send_rdy_i  (send_ready_o),
    .nak_evt_i   (nak_evt),
    .nak_clr_i   (nak_clr_i),
    .xmit_idle_o (xmit_idle_o),
    .nak_sent_o  (nak_sent_o),
    .irq_o       (irq_o)
  );

  assert_last_is_valid_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_last_o |-> tx_valid_o);
endmodule

// File: tb/in_ep_send_queue_tb.sv
module in_ep_send_queue_tb;
  localparam int SLOT_W = 4;
  localparam int WL2    = 6;
  localparam int LEN_W  = WL2 + 3;
  localparam int ADDR_W = SLOT_W + WL2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic usb_rst = 0, send_wr = 0, token = 0, ack = 0, tmo = 0, nak_clr = 0;
  logic [SLOT_W-1:0] slot = '0;
  logic [LEN_W-1:0]  len = '0;
  logic send_ready, mem_rd, tx_valid, tx_last, tx_zlp, nak, nak_sent, idle, irq;
  logic [ADDR_W-1:0] mem_addr;
  logic [31:0]       mem_data = '0;
  logic [7:0]        tx_data;

  always #5 clk = ~clk;

  in_ep_send_queue #(.SLOT_W(SLOT_W), .WORD_LOG2(WL2)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .usb_reset_i(usb_rst),
    .send_wr_i(send_wr), .send_slot_i(slot), .send_len_i(len), .send_ready_o(send_ready),
    .in_token_i(token), .ack_i(ack), .timeout_i(tmo),
    .mem_rd_o(mem_rd), .mem_addr_o(mem_addr), .mem_data_i(mem_data),
    .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_last_o(tx_last), .tx_zlp_o(tx_zlp),
    .nak_o(nak), .nak_clr_i(nak_clr), .nak_sent_o(nak_sent),
    .xmit_idle_o(idle), .irq_o(irq)
  );

  function automatic logic [31:0] word_of(input logic [ADDR_W-1:0] a);
    return {a[7:0] ^ 8'h5A, a[9:2] + 8'h33, ~a[7:0], {a[1:0], a[9:4]}};
  endfunction

  always_ff @(posedge clk) if (mem_rd) mem_data <= word_of(mem_addr);

  int nchk = 0, nerr = 0, cyc = 0;
  logic [7:0] got [0:511];
  int got_n, last_n, last_at;

  task automatic chk(input string req, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic wr_send(input int s, input int l);
    send_wr = 1; slot = SLOT_W'(s); len = LEN_W'(l);
    tick(); send_wr = 0;
  endtask
  task automatic p_token(); token = 1; tick(); token = 0; endtask
  task automatic p_ack();   ack = 1;   tick(); ack = 0;   endtask
  task automatic p_tmo();   tmo = 1;   tick(); tmo = 0;   endtask
  task automatic p_usb();   usb_rst = 1; tick(); usb_rst = 0; endtask

  task automatic collect();
    got_n = 0; last_n = 0; last_at = -1;
    for (int k = 0; k < 1500; k++) begin
      if (tx_valid) begin
        got[got_n] = tx_data;
        got_n++;
        if (tx_last) begin last_n++; last_at = got_n; end
      end
      if (last_n != 0) begin tick(); break; end
      tick();
    end
  endtask

  task automatic check_pkt(input string req, input int s, input int l);
    int bad = 0, first_act = 0, first_exp = 0;
    chk(req, "byte count", got_n, l);
    chk(req, "last position", last_at, l);
    chk(req, "last count", last_n, 1);
    for (int i = 0; i < got_n && i < l; i++) begin
      logic [31:0] w;
      logic [7:0]  e;
      w = word_of(ADDR_W'(s * 64 + i / 4));
      e = w[31 - 8 * (i % 4) -: 8];
      if (got[i] != e && bad == 0) begin first_act = got[i]; first_exp = e; end
      if (got[i] != e) bad++;
    end
    chk(req, "first mismatching byte (R1 R2)", first_act, first_exp);
  endtask

  task automatic quiet(input string req, input int n);
    int v = 0;
    for (int k = 0; k < n; k++) begin if (tx_valid) v++; tick(); end
    chk(req, "no bytes expected", v, 0);
  endtask

  // {slot, len}
  localparam logic [12:0] VEC [6] = '{
    {4'd0, 9'd1}, {4'd1, 9'd4}, {4'd3, 9'd5},
    {4'd15, 9'd9}, {4'd2, 9'd64}, {4'd5, 9'd256}
  };

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      nerr++; nchk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    chk("R11", "idle", idle, 1);
    chk("R11", "ready", send_ready, 0);
    chk("R11", "nak_sent", nak_sent, 0);
    chk("R11", "tx_valid", tx_valid, 0);
    chk("R11", "irq", irq, 0);

    foreach (VEC[v]) begin
      int s, l;
      s = int'(VEC[v][12:9]); l = int'(VEC[v][8:0]);
      wr_send(s, l);
      chk("R3", "ready after write", send_ready, 1);
      tick();
      chk("R3", "ready after handoff", send_ready, 0);
      chk("R3", "idle after handoff", idle, 0);
      p_token();
      collect();
      check_pkt("R5", s, l);
      p_ack();
      chk("R8", "irq on ack", irq, 1);
      chk("R8", "idle on ack", idle, 1);
      tick();
      chk("R8", "irq one cycle", irq, 0);
    end

    // R7 nak with nothing held
    p_token();
    chk("R7", "nak pulse", nak, 1);
    chk("R7", "nak_sent", nak_sent, 1);
    tick();
    chk("R7", "nak pulse ends", nak, 0);
    nak_clr = 1; tick(); nak_clr = 0;
    chk("R7", "nak cleared", nak_sent, 0);
    token = 1; nak_clr = 1; tick(); token = 0; nak_clr = 0;
    chk("R7", "set wins over clear", nak_sent, 1);
    nak_clr = 1; tick(); nak_clr = 0;

    // R6 zero-length
    wr_send(2, 0); tick();
    p_token();
    chk("R6", "zlp pulse", tx_zlp, 1);
    quiet("R6", 6);
    p_ack();
    chk("R6", "idle after zlp ack", idle, 1);

    // R9 timeout resend
    wr_send(7, 6); tick();
    p_token(); collect(); check_pkt("R9", 7, 6);
    p_tmo();
    chk("R9", "idle after timeout", idle, 0);
    tick();
    p_token(); collect(); check_pkt("R9", 7, 6);
    p_ack();
    chk("R9", "idle after final ack", idle, 1);

    // R8 stray ack ignored
    wr_send(1, 2); tick();
    p_ack();
    chk("R8", "stray ack idle", idle, 0);
    chk("R8", "stray ack irq", irq, 0);
    p_token(); collect(); check_pkt("R8", 1, 2);
    p_ack();

    // R3 holding full keeps request pending
    wr_send(3, 4); tick();
    wr_send(4, 5);
    chk("R3", "ready while held", send_ready, 1);
    tick();
    chk("R3", "ready still pending", send_ready, 1);
    p_token(); collect(); check_pkt("R3", 3, 4);
    p_ack();
    chk("R8", "no irq with pending", irq, 0);
    chk("R8", "idle low with pending", idle, 0);
    tick();
    chk("R3", "pending handed off", send_ready, 0);
    p_token(); collect(); check_pkt("R3", 4, 5);
    p_ack();

    // R4 write in handoff cycle
    wr_send(5, 3); tick();
    wr_send(6, 2);
    p_token(); collect(); check_pkt("R4", 5, 3);
    p_ack();
    wr_send(8, 7);
    chk("R4", "new request pending", send_ready, 1);
    chk("R4", "idle low", idle, 0);
    p_token(); collect(); check_pkt("R4", 6, 2);
    p_ack(); tick();
    p_token(); collect(); check_pkt("R4", 8, 7);
    p_ack();
    chk("R4", "idle at end", idle, 1);

    // R5 token during stream ignored
    wr_send(9, 12); tick();
    p_token(); p_token();
    collect(); check_pkt("R5", 9, 12);
    quiet("R5", 8);
    p_ack();

    // R10 bus reset
    wr_send(10, 8); tick();
    wr_send(11, 4);
    p_token(); p_token();
    p_usb();
    chk("R10", "ready cleared", send_ready, 0);
    chk("R10", "idle set", idle, 1);
    chk("R10", "no irq", irq, 0);
    p_token();
    chk("R10", "holding cleared gives nak", nak, 1);
    tick();
    chk("R10", "nak_sent before reset", nak_sent, 1);
    wr_send(12, 40); tick();
    p_token(); repeat (4) tick();
    p_usb();
    chk("R10", "nak_sent cleared", nak_sent, 0);
    chk("R10", "idle after abort", idle, 1);
    quiet("R10", 10);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule